// File: doc/BRIEF.md
# Control-flow unit for an 8-bit CPU

This unit carries out the branch, return and interrupt-enable instructions of a small 8-bit processor that has a 16-bit address space. The issuing pipeline presents one opcode byte, two immediate bytes, the zero and carry flags, and the current program counter, stack pointer and HL pair. It then pulses `start`. When the instruction has finished, the unit reports the successor program counter and stack pointer and raises `done` for one cycle. It also holds the interrupt master enable bit.

Instructions that only move registers finish in the cycle after they are accepted. A taken return pops two bytes through a byte-wide read port that uses a request/valid handshake. The low byte is read first, from the stack pointer. The high byte is read next, from the following address. The stack pointer moves past both bytes. A conditional instruction whose condition is false makes no memory access, leaves the stack pointer as it is, and moves the program counter past the instruction.

Top module: `flow_ctrl_unit`

## Requirements
- R1: The opcode is decoded only from three fields: x = bits 7:6, y = bits 5:3 and z = bits 2:0. With x=3, the opcodes map as follows:
  - z=0 with y=0..3 is a conditional return.
  - z=1 with y=1 is return, y=3 is return-from-interrupt, y=5 is jump to HL and y=7 is load SP from HL.
  - z=2 with y=0..3 is a conditional jump.
  - z=3 with y=0 is an absolute jump, y=6 disables interrupts and y=7 enables interrupts.
- R2: The condition code is y[1:0]. Code 0 is true when Z=0 and code 1 when Z=1. Code 2 is true when C=0 and code 3 when C=1.
- R3: An absolute jump (0xC3) loads PC with {imm_hi, imm_lo}, where imm_lo is the first immediate byte. SP is unchanged.
- R4: A conditional jump (0xC2, 0xCA, 0xD2, 0xDA) loads PC with {imm_hi, imm_lo} when its condition is true, and with pc_in+3 when it is false. SP is unchanged in both cases.
- R5: Jump to HL (0xE9) gives PC = hl_in and leaves SP unchanged. Load SP from HL (0xF9) gives SP = hl_in and PC = pc_in+1.
- R6: A return (0xC9, or a conditional return whose condition is true) makes two reads. The first is at sp_in and the second at sp_in+1. It gives PC = {second byte, first byte} and SP = sp_in+2. All address arithmetic wraps modulo 2^16.
- R7: A conditional return (0xC0, 0xC8, 0xD0, 0xD8) whose condition is false makes no memory request. It gives PC = pc_in+1 and leaves SP unchanged.
- R8: Return-from-interrupt (0xD9) sets the interrupt enable and then performs the return of R6.
- R9: Disable interrupts (0xF3) clears the interrupt enable and enable interrupts (0xFB) sets it. Both give PC = pc_in+1.
- R10: While mem_req is high and mem_valid is low, mem_req stays high and mem_addr holds its value.
- R11: `done` is high for exactly one cycle at the end of each instruction. A non-memory instruction ends in the cycle after `start` is sampled. A `start` that arrives while a return is in progress is ignored.
- R12: Any other opcode, such as 0x00 or 0xCD, gives PC = pc_in+1 and leaves SP and the interrupt enable unchanged.
- R13: During reset, ime, done and mem_req are 0, and pc_next and sp_next are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue the presented instruction |
| opcode | input | 8 | Instruction byte |
| imm_lo | input | 8 | First immediate byte (target low byte) |
| imm_hi | input | 8 | Second immediate byte (target high byte) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Address of the current instruction |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | Current HL pair |
| mem_valid | input | 1 | Read data is valid |
| mem_rdata | input | 8 | Read data byte |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| pc_next | output | 16 | Successor program counter |
| sp_next | output | 16 | Successor stack pointer |
| ime | output | 1 | Interrupt master enable |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
Each of the four condition codes is tried with its flag set and then cleared. This separates the true form of each test from its negated form, and separates the zero flag from the carry flag. Returns are run with memory latencies of zero and two cycles, which separates a correct handshake from one that times out or reads early. A stack pointer of 0xFFFF checks that the address wraps between the two pops. The stack bytes are a function of their address, so swapped bytes or a wrong read address show up in the result.

Running the same opcodes with their conditions false confirms that no read is issued and that PC moves past the instruction. A `start` injected during a pop shows that the interrupt enable is unaffected by an instruction that arrives while the unit is busy.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2 * DW;
  localparam int unsigned LW = 2;

  typedef enum logic [2:0] {
    OP_OTHER, OP_JP, OP_JPHL, OP_RET, OP_LDSP, OP_DI, OP_EI
  } op_kind_e;

  typedef struct packed {
    op_kind_e        kind;
    logic            cond_en;
    logic [1:0]      cc;
    logic            reti;
    logic [LW-1:0]   len;
  } dec_t;

  // 2-3-3 field split, only x/y/z are consulted
  function automatic dec_t decode_op(input logic [DW-1:0] op);
    dec_t d;
    logic [1:0] x;
    logic [2:0] y;
    logic [2:0] z;
    x = op[7:6];
    y = op[5:3];
    z = op[2:0];
    d.kind    = OP_OTHER;
    d.cond_en = 1'b0;
    d.cc      = y[1:0];
    d.reti    = 1'b0;
    d.len     = LW'(1);
    if (x == 2'd3) begin
      case (z)
        3'd0: if (!y[2]) begin d.kind = OP_RET; d.cond_en = 1'b1; end
        3'd1: begin
          case (y)
            3'd1: d.kind = OP_RET;
            3'd3: begin d.kind = OP_RET; d.reti = 1'b1; end
            3'd5: d.kind = OP_JPHL;
            3'd7: d.kind = OP_LDSP;
            default: d.kind = OP_OTHER;
          endcase
        end
        3'd2: if (!y[2]) begin d.kind = OP_JP; d.cond_en = 1'b1; d.len = LW'(3); end
        3'd3: begin
          case (y)
            3'd0: begin d.kind = OP_JP; d.len = LW'(3); end
            3'd6: d.kind = OP_DI;
            3'd7: d.kind = OP_EI;
            default: d.kind = OP_OTHER;
          endcase
        end
        default: d.kind = OP_OTHER;
      endcase
    end
    return d;
  endfunction

  // bit 1 selects the flag, bit 0 selects true or negated form
  function automatic logic cond_holds(input logic [1:0] cc, input logic z, input logic c);
    logic f;
    f = cc[1] ? c : z;
    return cc[0] ? f : ~f;
  endfunction

  function automatic logic [AW-1:0] join_le(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction
endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
  import cfu_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);
  always_comb dec = decode_op(opcode);
endmodule

// File: rtl/cfu_cond.sv
module cfu_cond
  import cfu_pkg::*;
(
  input  dec_t dec,
  input  logic flag_z,
  input  logic flag_c,
  output logic take
);
  always_comb take = !dec.cond_en || cond_holds(dec.cc, flag_z, flag_c);
endmodule

// File: rtl/cfu_seq.sv
module cfu_seq
  import cfu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  dec_t          dec,
  input  logic          take,
  input  logic [DW-1:0] imm_lo,
  input  logic [DW-1:0] imm_hi,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] hl_in,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] sp_next,
  output logic          ime,
  output logic          done,
  output logic          accept,
  output logic          lo_fire,
  output logic          hi_fire,
  output logic [DW-1:0] lo_byte
);
  typedef enum logic [1:0] {S_IDLE, S_POP_LO, S_POP_HI} st_e;
  st_e state;
  logic [AW-1:0] ptr;
  logic [AW-1:0] fall_pc;

  assign accept   = start && (state == S_IDLE);
  assign lo_fire  = (state == S_POP_LO) && mem_valid;
  assign hi_fire  = (state == S_POP_HI) && mem_valid;
  assign mem_req  = (state != S_IDLE);
  assign mem_addr = ptr;
  assign fall_pc  = pc_in + AW'(dec.len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      lo_byte <= '0;
      pc_next <= '0;
      sp_next <= '0;
      ime     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          pc_next <= fall_pc;
          sp_next <= sp_in;
          done    <= 1'b1;
          case (dec.kind)
            OP_JP:   if (take) pc_next <= join_le(imm_lo, imm_hi);
            OP_JPHL: pc_next <= hl_in;
            OP_LDSP: sp_next <= hl_in;
            OP_DI:   ime <= 1'b0;
            OP_EI:   ime <= 1'b1;
            OP_RET:  if (take) begin
              if (dec.reti) ime <= 1'b1;
              ptr     <= sp_in;
              pc_next <= pc_next;
              sp_next <= sp_next;
              done    <= 1'b0;
              state   <= S_POP_LO;
            end
            default: ;
          endcase
        end
        S_POP_LO: if (mem_valid) begin
          lo_byte <= mem_rdata;
          ptr     <= addr_inc(ptr);
          state   <= S_POP_HI;
        end
        S_POP_HI: if (mem_valid) begin
          pc_next <= join_le(lo_byte, mem_rdata);
          sp_next <= addr_inc(ptr);
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import cfu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] opcode,
  input  logic [DW-1:0] imm_lo,
  input  logic [DW-1:0] imm_hi,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] hl_in,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] sp_next,
  output logic          ime,
  output logic          done
);
  dec_t          dec;
  logic          take;
  logic          accept;
  logic          lo_fire;
  logic          hi_fire;
  logic [DW-1:0] lo_byte;

  cfu_decode u_dec (.opcode(opcode), .dec(dec));
  cfu_cond   u_cond (.dec(dec), .flag_z(flag_z), .flag_c(flag_c), .take(take));
  cfu_seq    u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dec(dec), .take(take),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .pc_next(pc_next), .sp_next(sp_next), .ime(ime),
    .done(done), .accept(accept), .lo_fire(lo_fire), .hi_fire(hi_fire),
    .lo_byte(lo_byte)
  );
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker
  import cfu_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic [AW-1:0] pc_next,
  input logic [AW-1:0] sp_next,
  input logic          ime,
  input logic          done,
  input logic          accept,
  input logic          take,
  input dec_t          dec,
  input logic          lo_fire,
  input logic          hi_fire
);
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  p_second_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_fire |=> mem_addr == $past(mem_addr) + AW'(1));

  p_ret_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_fire |=> done && sp_next == $past(mem_addr) + AW'(1));

  p_ret_pc_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_fire |=> pc_next[AW-1:DW] == $past(mem_rdata));

  p_false_nomem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !take |=> !mem_req && done);

  p_reti_ime_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && take && dec.reti |=> ime && mem_req);

  p_ei_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.kind == OP_EI |=> ime);

  p_di_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.kind == OP_DI |=> !ime);

  p_quick_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(dec.kind == OP_RET && take) |=> done);

  p_idle_no_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !hi_fire |=> !done);

  p_reset_r13: assert property (@(posedge clk)
    !rst_n |=> !ime && !done && !mem_req);
endmodule

bind flow_ctrl_unit cfu_checker u_chk (.*);

// File: tb/tb_flow_ctrl_unit.sv
module tb_flow_ctrl_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, imm_lo = '0, imm_hi = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_req;
  logic [15:0] mem_addr, pc_next, sp_next;
  logic        ime, done;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] got_pc, got_sp, rd0, rd1;
  int nreads;
  bit addr_ok, saw_done;

  flow_ctrl_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] stack_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic bit cond_ok(input logic [1:0] cc, input bit z, input bit c);
    bit flag;
    flag = (cc < 2) ? z : c;
    return flag == (cc == 2'd1 || cc == 2'd3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                      input bit z, input bit c, input logic [15:0] pc,
                      input logic [15:0] sp, input logic [15:0] hl,
                      input int lat, input bit inject);
    int wc;
    logic [15:0] hold;
    @(negedge clk);
    opcode = op; imm_lo = lo; imm_hi = hi; flag_z = z; flag_c = c;
    pc_in = pc; sp_in = sp; hl_in = hl; start = 1'b1;
    wc = 0; nreads = 0; addr_ok = 1; saw_done = 0; hold = '0;
    for (int i = 0; i < 40 && !saw_done; i++) begin
      @(negedge clk);
      start = inject && (i == 1);
      if (inject) opcode = 8'hFB;
      mem_valid = 1'b0;
      if (done) begin
        got_pc = pc_next; got_sp = sp_next; saw_done = 1;
      end else if (mem_req) begin
        if (wc == 0) hold = mem_addr;
        else if (mem_addr != hold) addr_ok = 0;
        if (wc == lat) begin
          mem_valid = 1'b1;
          mem_rdata = stack_byte(mem_addr);
          if (nreads == 0) rd0 = mem_addr; else rd1 = mem_addr;
          nreads++;
          wc = 0;
        end else wc++;
      end
    end
    start = 1'b0;
    chk(saw_done, "R11 done seen", 32'(saw_done), 32'd1);
    chk(addr_ok, "R10 address held while waiting", 32'(addr_ok), 32'd1);
    @(negedge clk);
    chk(!done, "R11 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_jump_abs();
    exec(8'hC3, 8'h34, 8'h12, 0, 0, 16'h0100, 16'hC000, 16'h5555, 0, 0);
    chk(got_pc == 16'h1234, "R3 jump target", got_pc, 16'h1234);
    chk(got_sp == 16'hC000, "R3 sp kept", got_sp, 16'hC000);
  endtask

  task automatic t_jump_cond();
    for (int cc = 0; cc < 4; cc++) begin
      for (int f = 0; f < 2; f++) begin
        bit z, c;
        logic [15:0] exp;
        z = (cc < 2) ? f[0] : ~f[0];
        c = (cc < 2) ? ~f[0] : f[0];
        exp = cond_ok(2'(cc), z, c) ? 16'hBEEF : 16'h0203;
        exec(8'hC2 | 8'(cc << 3), 8'hEF, 8'hBE, z, c, 16'h0200, 16'hD000, 16'h0, 1, 0);
        chk(got_pc == exp, "R4 R2 conditional jump pc", got_pc, exp);
        chk(got_sp == 16'hD000, "R4 sp kept", got_sp, 16'hD000);
        chk(nreads == 0, "R4 no memory", 32'(nreads), 32'd0);
      end
    end
  endtask

  task automatic t_hl_ops();
    exec(8'hE9, 8'h0, 8'h0, 0, 0, 16'h0300, 16'hAAAA, 16'h4321, 0, 0);
    chk(got_pc == 16'h4321, "R5 jump to HL pc", got_pc, 16'h4321);
    chk(got_sp == 16'hAAAA, "R5 jump to HL sp", got_sp, 16'hAAAA);
    exec(8'hF9, 8'h0, 8'h0, 0, 0, 16'h0300, 16'hAAAA, 16'h7E00, 0, 0);
    chk(got_sp == 16'h7E00, "R5 load SP sp", got_sp, 16'h7E00);
    chk(got_pc == 16'h0301, "R5 load SP pc", got_pc, 16'h0301);
  endtask

  task automatic t_ret(input logic [15:0] sp, input int lat);
    logic [15:0] e;
    e = {stack_byte(sp + 16'd1), stack_byte(sp)};
    exec(8'hC9, 8'h0, 8'h0, 0, 0, 16'h0400, sp, 16'h0, lat, 0);
    chk(nreads == 2, "R6 two reads", 32'(nreads), 32'd2);
    chk(rd0 == sp, "R6 first read address", rd0, sp);
    chk(rd1 == sp + 16'd1, "R6 second read address", rd1, sp + 16'd1);
    chk(got_pc == e, "R6 return pc", got_pc, e);
    chk(got_sp == sp + 16'd2, "R6 return sp", got_sp, sp + 16'd2);
  endtask

  task automatic t_ret_cond();
    for (int cc = 0; cc < 4; cc++) begin
      for (int f = 0; f < 2; f++) begin
        bit z, c, t;
        z = f[0]; c = f[0];
        t = cond_ok(2'(cc), z, c);
        exec(8'hC0 | 8'(cc << 3), 8'h0, 8'h0, z, c, 16'h0500, 16'hCFF0, 16'h0, 1, 0);
        if (t) begin
          chk(got_pc == {stack_byte(16'hCFF1), stack_byte(16'hCFF0)}, "R6 R2 taken return pc",
              got_pc, {stack_byte(16'hCFF1), stack_byte(16'hCFF0)});
          chk(got_sp == 16'hCFF2, "R6 taken return sp", got_sp, 16'hCFF2);
        end else begin
          chk(nreads == 0, "R7 no request", 32'(nreads), 32'd0);
          chk(got_pc == 16'h0501, "R7 R2 skipped return pc", got_pc, 16'h0501);
          chk(got_sp == 16'hCFF0, "R7 skipped return sp", got_sp, 16'hCFF0);
        end
      end
    end
  endtask

  task automatic t_ime();
    exec(8'hF3, 8'h0, 8'h0, 0, 0, 16'h0600, 16'h1, 16'h0, 0, 0);
    chk(ime == 1'b0, "R9 disable", 32'(ime), 32'd0);
    chk(got_pc == 16'h0601, "R9 disable pc", got_pc, 16'h0601);
    exec(8'hD9, 8'h0, 8'h0, 0, 0, 16'h0600, 16'hE000, 16'h0, 2, 0);
    chk(ime == 1'b1, "R8 reti sets enable", 32'(ime), 32'd1);
    chk(got_pc == {stack_byte(16'hE001), stack_byte(16'hE000)}, "R8 reti pc",
        got_pc, {stack_byte(16'hE001), stack_byte(16'hE000)});
    chk(got_sp == 16'hE002, "R8 reti sp", got_sp, 16'hE002);
    exec(8'hF3, 8'h0, 8'h0, 0, 0, 16'h0600, 16'h1, 16'h0, 0, 0);
    chk(ime == 1'b0, "R9 disable again", 32'(ime), 32'd0);
    exec(8'hFB, 8'h0, 8'h0, 0, 0, 16'h0610, 16'h1, 16'h0, 0, 0);
    chk(ime == 1'b1, "R9 enable", 32'(ime), 32'd1);
    chk(got_pc == 16'h0611, "R9 enable pc", got_pc, 16'h0611);
  endtask

  task automatic t_busy();
    exec(8'hF3, 8'h0, 8'h0, 0, 0, 16'h0700, 16'h1, 16'h0, 0, 0);
    exec(8'hC9, 8'h0, 8'h0, 0, 0, 16'h0700, 16'h8000, 16'h0, 2, 1);
    chk(ime == 1'b0, "R11 start ignored while busy", 32'(ime), 32'd0);
    chk(got_sp == 16'h8002, "R11 return intact", got_sp, 16'h8002);
  endtask

  task automatic t_other();
    exec(8'hFB, 8'h0, 8'h0, 0, 0, 16'h0800, 16'h2, 16'h0, 0, 0);
    exec(8'h00, 8'h11, 8'h22, 1, 1, 16'h0800, 16'h2222, 16'h9999, 0, 0);
    chk(got_pc == 16'h0801, "R12 other pc", got_pc, 16'h0801);
    chk(got_sp == 16'h2222, "R12 other sp", got_sp, 16'h2222);
    exec(8'hCD, 8'h11, 8'h22, 1, 1, 16'h0900, 16'h3333, 16'h9999, 0, 0);
    chk(got_pc == 16'h0901, "R12 R1 call opcode pc", got_pc, 16'h0901);
    chk(ime == 1'b1, "R12 enable unchanged", 32'(ime), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ime && !done && !mem_req, "R13 reset controls", {ime, done, mem_req}, 32'd0);
    chk(pc_next == 16'h0 && sp_next == 16'h0, "R13 reset outputs", {pc_next, sp_next}, 32'd0);
    rst_n = 1'b1;
    t_jump_abs();
    t_jump_cond();
    t_hl_ops();
    t_ret(16'hC100, 0);
    t_ret(16'hC101, 2);
    t_ret(16'hFFFF, 1);
    t_ret_cond();
    t_ime();
    t_busy();
    t_other();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule